// File: doc/BRIEF.md
# PWM Output Action Qualifier with Software Override

This block drives two PWM output pins from events supplied by a separate time-base counter. On every time-base tick it looks for four events: the counter at zero, the counter at period, the counter equal to compare value A while counting up, and the counter equal to compare value B while counting up. Each pin has its own action register that assigns one of four actions to each event: no action, drive low, drive high or toggle. A program sets the usual polarities by writing these registers. Normal polarity drives the pin high at zero and at period and low on the pin's own compare match. Inverted polarity does the reverse.

Software can also hold either pin at a fixed level through a continuous override register. A new override setting does not reach the pins when it is written. It waits in a staging register until a reload point that software picks: counter zero, counter period, either of them, or the next tick. While an override is in force it wins over every event action on that pin. When it is released, the pin keeps its last level until the next event action.

Top module: `pwm_action_qual`

## Requirements
- R1: During reset and in the first cycle after it, both pins are low and no override is active.
- R2: Register writes use `wr_sel`: 0 selects the action register of pin A, 1 selects the action register of pin B and 2 selects the override register. In an action register, bits 1:0 hold the zero action, bits 3:2 the period action, bits 5:4 the compare-A action and bits 9:8 the compare-B action. Action codes are 00 none, 01 low, 10 high and 11 toggle.
- R3: A compare event needs `cnt_up` high and `cnt` equal to the compare value. Ticks that match the same compare back to back produce only one event.
- R4: Each pin uses only its own action register, and either pin may respond to either compare value.
- R5: When several events occur on one tick, the highest-priority event whose action code is not 00 decides the pin. The order from highest to lowest is compare B, compare A, period, zero.
- R6: Override bits 1:0 control pin A and bits 3:2 control pin B. Code 01 holds the pin low, code 10 holds it high, and codes 00 and 11 release it. An active override masks all event actions on its pin.
- R7: Override bits 7:6 choose when the staged override becomes active: 00 on a tick at zero, 01 on a tick at period, 10 on a tick at zero or period, 11 on the next tick.
- R8: The pins change only on cycles where `tick` is high.
- R9: After an override is released, the pin holds its level until the next event action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base tick enable |
| cnt | input | 16 | Time-base counter value |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| at_zero | input | 1 | Counter-at-zero strobe |
| at_period | input | 1 | Counter-at-period strobe |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | PWM pin A |
| pwm_b | output | 1 | PWM pin B |

## Verification
Each action field is tested on its own, with a single event per tick, so that a wrong field position or a wrong code mapping shows up as a wrong level. Coinciding events are tested with actions of opposite sense, so that the pin level shows which event won. One case places a 00 action on the winning event, which shows whether an empty code blocks a lower-priority event. Compare ticks are applied counting down, off by one, and repeated on the same count, which separates direction gating from the one-event-per-match rule. Override writes are followed by ticks at a non-matching point, at zero and at period under each reload choice, which shows the exact tick on which the staged value takes over and the level the pin keeps once it is released.

// File: rtl/pwm_action_qual.sv
module pwm_action_qual #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_up,
  input  logic          at_zero,
  input  logic          at_period,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [15:0]   wr_data,
  output logic          pwm_a,
  output logic          pwm_b
);

  logic [9:0] act_a, act_b;
  logic [3:0] frc_pend, frc_act, frc_nx;
  logic [1:0] rld;
  logic       hit_a, hit_b, ma_q, mb_q, ev_ca, ev_cb, load_frc;

  assign hit_a = cnt_up && (cnt == cmp_a);
  assign hit_b = cnt_up && (cnt == cmp_b);
  assign ev_ca = hit_a && !ma_q;
  assign ev_cb = hit_b && !mb_q;

  always_comb begin
    case (rld)
      2'b00:   load_frc = tick && at_zero;
      2'b01:   load_frc = tick && at_period;
      2'b10:   load_frc = tick && (at_zero || at_period);
      default: load_frc = tick;
    endcase
  end

  assign frc_nx = load_frc ? frc_pend : frc_act;

  function automatic logic resolve(input logic cur, input logic [9:0] act,
                                   input logic ez, input logic ep,
                                   input logic eca, input logic ecb,
                                   input logic [1:0] frc);
    logic [1:0] pick;
    pick = 2'b00;
    if (ez  && act[1:0] != 2'b00) pick = act[1:0];
    if (ep  && act[3:2] != 2'b00) pick = act[3:2];
    if (eca && act[5:4] != 2'b00) pick = act[5:4];
    if (ecb && act[9:8] != 2'b00) pick = act[9:8];
    if (frc == 2'b01)      return 1'b0;
    else if (frc == 2'b10) return 1'b1;
    case (pick)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return !cur;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a    <= '0;
      act_b    <= '0;
      frc_pend <= '0;
      rld      <= '0;
      frc_act  <= '0;
      ma_q     <= 1'b0;
      mb_q     <= 1'b0;
      pwm_a    <= 1'b0;
      pwm_b    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          2'd0: act_a <= wr_data[9:0];
          2'd1: act_b <= wr_data[9:0];
          2'd2: begin
            frc_pend <= wr_data[3:0];
            rld      <= wr_data[7:6];
          end
          default: ;
        endcase
      end
      if (tick) begin
        ma_q    <= hit_a;
        mb_q    <= hit_b;
        frc_act <= frc_nx;
        pwm_a   <= resolve(pwm_a, act_a, at_zero, at_period, ev_ca, ev_cb, frc_nx[1:0]);
        pwm_b   <= resolve(pwm_b, act_b, at_zero, at_period, ev_ca, ev_cb, frc_nx[3:2]);
      end
    end
  end

endmodule

module pwm_aq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cnt_up,
  input logic       at_zero,
  input logic       at_period,
  input logic [1:0] rld,
  input logic [3:0] frc_act,
  input logic       pwm_a,
  input logic       pwm_b
);

  assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pwm_a && !pwm_b && frc_act == 4'b0000));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

  assert_no_down_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_up && !at_zero && !at_period && rld != 2'b11)
      |=> ($stable(pwm_a) && $stable(pwm_b)));

  assert_force_low_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[1:0] == 2'b01) |-> !pwm_a);

  assert_force_high_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[1:0] == 2'b10) |-> pwm_a);

  assert_force_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_act[3:2] == 2'b01 || frc_act[3:2] == 2'b10) |-> (pwm_b == frc_act[3]));

endmodule

bind pwm_action_qual pwm_aq_checks u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_up(cnt_up),
  .at_zero(at_zero), .at_period(at_period), .rld(rld),
  .frc_act(frc_act), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/pwm_action_qual_test.sv
module pwm_action_qual_test;
  logic        clk = 0, rst_n = 0, tick = 0, cnt_up = 1, at_zero = 0, at_period = 0;
  logic [15:0] cnt = 16'd12345, cmp_a = 16'd1000, cmp_b = 16'd2000, wr_data = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic        pwm_a, pwm_b;
  int          n_chk = 0, n_bad = 0;

  pwm_action_qual uut (.*);

  always #4 clk = !clk;

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; wr_en = 0;
    cmp_a = 16'd1000; cmp_b = 16'd2000;
    @(negedge clk); @(negedge clk); rst_n = 1;
    chk("R1 pin A after reset", pwm_a, 1'b0);
    chk("R1 pin B after reset", pwm_b, 1'b0);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [15:0] c, input logic up, input logic z, input logic p);
    @(negedge clk); cnt = c; cnt_up = up; at_zero = z; at_period = p; tick = 1;
    @(negedge clk); tick = 0; at_zero = 0; at_period = 0; cnt = 16'd12345;
  endtask

  task automatic t_encoding();
    do_reset();
    wr(0, 16'h0002); pulse(0, 1, 1, 0); chk("R2 zero high", pwm_a, 1);
    wr(0, 16'h0001); pulse(0, 1, 1, 0); chk("R2 zero low", pwm_a, 0);
    wr(0, 16'h0003); pulse(0, 1, 1, 0); chk("R2 toggle up", pwm_a, 1);
    pulse(0, 1, 1, 0); chk("R2 toggle down", pwm_a, 0);
    wr(0, 16'h0002); pulse(0, 1, 1, 0);
    wr(0, 16'h0000); pulse(0, 1, 1, 0); chk("R2 no action", pwm_a, 1);
    wr(0, 16'h0004); pulse(9, 1, 0, 1); chk("R2 period field", pwm_a, 0);
    cmp_a = 50; wr(0, 16'h0020); pulse(50, 1, 0, 0); chk("R2 compare A field", pwm_a, 1);
    cmp_b = 60; wr(0, 16'h0100); pulse(60, 1, 0, 0); chk("R2 compare B field", pwm_a, 0);
  endtask

  task automatic t_compare();
    do_reset();
    cmp_a = 50; wr(0, 16'h0020);
    pulse(50, 0, 0, 0); chk("R3 down count ignored", pwm_a, 0);
    pulse(49, 1, 0, 0); chk("R3 off by one", pwm_a, 0);
    pulse(50, 1, 0, 0); chk("R3 up match", pwm_a, 1);
    wr(0, 16'h0030);
    pulse(50, 1, 0, 0); chk("R3 repeated match once", pwm_a, 1);
    pulse(51, 1, 0, 0); chk("R3 no match", pwm_a, 1);
    pulse(50, 1, 0, 0); chk("R3 new match toggles", pwm_a, 0);
  endtask

  task automatic t_indep();
    do_reset();
    wr(0, 16'h0002); wr(1, 16'h0001); pulse(0, 1, 1, 0);
    chk("R4 A own reg", pwm_a, 1); chk("R4 B own reg", pwm_b, 0);
    wr(0, 16'h0001); wr(1, 16'h0002); pulse(0, 1, 1, 0);
    chk("R4 A swapped", pwm_a, 0); chk("R4 B swapped", pwm_b, 1);
    cmp_a = 70; wr(1, 16'h0010); pulse(70, 1, 0, 0);
    chk("R4 B on compare A", pwm_b, 0); chk("R4 A untouched", pwm_a, 0);
  endtask

  task automatic t_priority();
    do_reset();
    wr(0, 16'h0002); pulse(0, 1, 1, 0);
    wr(0, 16'h0012); cmp_a = 0; pulse(0, 1, 1, 0); chk("R5 compare over zero", pwm_a, 0);
    pulse(12345, 1, 0, 0);
    wr(0, 16'h0210); cmp_a = 30; cmp_b = 30; pulse(30, 1, 0, 0); chk("R5 B over A", pwm_a, 1);
    pulse(12345, 1, 0, 0);
    wr(0, 16'h0001); cmp_a = 0; pulse(0, 1, 1, 0); chk("R5 empty code no block", pwm_a, 0);
    wr(0, 16'h0009); pulse(5, 1, 1, 1); chk("R5 period over zero", pwm_a, 1);
  endtask

  task automatic t_force();
    do_reset();
    wr(1, 16'h0002); pulse(0, 1, 1, 0);
    wr(2, 16'h00C2); pulse(12345, 1, 0, 0); chk("R6 force A high", pwm_a, 1);
    wr(0, 16'h0001); pulse(0, 1, 1, 0); chk("R6 force masks action", pwm_a, 1);
    wr(2, 16'h00C4); pulse(12345, 1, 0, 0);
    chk("R6 force B low", pwm_b, 0); chk("R9 A holds after release", pwm_a, 1);
    wr(1, 16'h0000); pulse(0, 1, 1, 0); chk("R9 action resumes", pwm_a, 0);
    wr(2, 16'h00CF); wr(0, 16'h0002); wr(1, 16'h0002); pulse(0, 1, 1, 0);
    chk("R6 code 11 no force A", pwm_a, 1); chk("R6 code 11 no force B", pwm_b, 1);
  endtask

  task automatic t_reload();
    do_reset();
    wr(0, 16'h0008);
    wr(2, 16'h0001); pulse(7, 1, 0, 1); chk("R7 zero mode waits", pwm_a, 1);
    pulse(0, 1, 1, 0); chk("R7 zero mode loads", pwm_a, 0);
    pulse(7, 1, 0, 1); chk("R7 force held", pwm_a, 0);
    wr(2, 16'h0040); pulse(0, 1, 1, 0); chk("R7 period mode waits", pwm_a, 0);
    pulse(7, 1, 0, 1); chk("R7 period mode loads", pwm_a, 1);
    wr(2, 16'h0081); pulse(12345, 1, 0, 0); chk("R7 either mode waits", pwm_a, 1);
    pulse(0, 1, 1, 0); chk("R7 either mode zero", pwm_a, 0);
    wr(2, 16'h0080); pulse(7, 1, 0, 1); chk("R7 either mode period", pwm_a, 1);
  endtask

  task automatic t_notick();
    do_reset();
    wr(0, 16'h0002);
    @(negedge clk); at_zero = 1; cnt = 0;
    repeat (3) @(negedge clk);
    chk("R8 no tick no change", pwm_a, 0);
    at_zero = 0;
    pulse(0, 1, 1, 0); chk("R8 tick applies", pwm_a, 1);
    wr(2, 16'h00C1); repeat (3) @(negedge clk);
    chk("R8 force waits for tick", pwm_a, 1);
    pulse(12345, 1, 0, 0); chk("R8 force on tick", pwm_a, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_encoding();
    t_compare();
    t_indep();
    t_priority();
    t_force();
    t_reload();
    t_notick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule